// File: doc/BRIEF.md
# Bipolar line encoder with eight-zero substitution

The block turns a serial stream of binary data bits into a three-level line code carried on two rails. One rail marks positive pulses and the other marks negative pulses. A zero bit leaves both rails low. Each one bit raises exactly one rail, and the rail alternates from one mark to the next. On a line coded this way the receiver takes its timing from the pulse edges, so a long stretch of zeros starves it of timing. For that reason, any eight consecutive zero bits are sent as a fixed eight-symbol pattern instead. That pattern carries pulses and breaks the alternation rule twice on purpose, and the two breaks let the far end recognise the pattern and restore the zeros.

A bit enters the block on each cycle in which the strobe `bit_valid_i` is high. Cycles in which the strobe is low do not advance the stream. Every bit sits in an eight-stage window before it is coded. This gives the block a full view of each possible eight-zero run before the first zero of that run leaves. Each input bit therefore appears on the rails eight strobes after it entered. It is presented, with `valid_o` high, during the cycle that follows the strobe that pushed it out.

Top module: `b8zs_encoder`

## Requirements
- R1: A zero bit that is not part of a substituted run is sent with both rails low (code {pos_o,neg_o} = 00).
- R2: Marks alternate between the positive rail (code 10) and the negative rail (code 01). After reset, the first mark is positive.
- R3: Eight consecutive input zeros are sent as the symbol sequence 0,0,0,V,B,0,V,B, oldest first. A V pulse has the same polarity as the pulse sent just before it. A B pulse has the opposite polarity to the pulse sent just before it. Right after reset, the pulse "sent before" counts as negative, so the first V is negative.
- R4: After a substitution, the next mark has the polarity opposite to the final B of the pattern.
- R5: Input bit k is presented, with valid_o high, in the cycle after the strobe that carries input bit k+8. The first eight strobes after reset produce no valid_o.
- R6: pos_o and neg_o are never high together, and both are low whenever valid_o is low.
- R7: The line never carries eight consecutive valid no-pulse symbols.
- R8: Cycles without a strobe neither advance the window nor change the polarity state, so idle gaps between bits leave the coded sequence unchanged.
- R9: Reset empties the window and restores the initial polarity state, including when it arrives in the middle of a stream.
- R10: A zero run of sixteen bits is sent as two back-to-back substitution patterns. A run of seven zeros between marks is sent as seven plain zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_valid_i | input | 1 | Strobe: bit_i carries a new data bit this cycle |
| bit_i | input | 1 | Serial data bit |
| pos_o | output | 1 | Positive-pulse rail |
| neg_o | output | 1 | Negative-pulse rail |
| valid_o | output | 1 | A coded symbol is on the rails this cycle |

## Verification
The hardest situations to reach are those where a substitution meets other state. One case is a pattern right after reset, when no pulse has yet been sent. Another is a pattern that directly follows an earlier pattern. A third is a zero run that straddles an eight-bit boundary, where a single zero left over after a pattern must not start a new one. Reaching them takes bit sequences of exact length. The bench therefore walks a table of sixteen-bit streams, each followed by a flush of ones. The table holds a run of eight zeros starting at reset, sixteen zeros in a row, nine zeros, and runs of seven, each with its expected rail codes. It then replays one stream with idle gaps and applies reset in the middle of a stream.

// File: rtl/b8zs_pkg.sv
package b8zs_pkg;

  localparam int unsigned RUN_LEN = 8;

  typedef enum logic [1:0] {
    SYM_ZERO = 2'd0,
    SYM_MARK = 2'd1,
    SYM_VIOL = 2'd2,
    SYM_BAL  = 2'd3
  } sym_e;

  // stage 0 is newest; line order oldest first is 0 0 0 V B 0 V B
  function automatic sym_e sub_sym(input int unsigned idx);
    case (idx)
      0, 3:    sub_sym = SYM_BAL;
      1, 4:    sub_sym = SYM_VIOL;
      default: sub_sym = SYM_ZERO;
    endcase
  endfunction

endpackage

// File: rtl/b8zs_window.sv
module b8zs_window
  import b8zs_pkg::*;
#(
  parameter int unsigned DEPTH = RUN_LEN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_i,
  input  logic bit_i,
  output sym_e head_o,
  output logic full_o
);

  localparam int unsigned FILL_W = $clog2(DEPTH + 1);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(DEPTH);
  localparam logic [FILL_W-1:0] FILL_HIT = FILL_W'(DEPTH - 1);

  sym_e sym_q   [DEPTH];
  sym_e shifted [DEPTH];
  sym_e sym_d   [DEPTH];
  logic [DEPTH-1:0] is_zero;
  logic [FILL_W-1:0] fill_q;
  logic run_hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_in
      assign shifted[i] = bit_i ? SYM_MARK : SYM_ZERO;
    end else begin : g_mid
      assign shifted[i] = sym_q[i-1];
    end
    assign is_zero[i] = (shifted[i] == SYM_ZERO);
    assign sym_d[i]   = run_hit ? sub_sym(i) : shifted[i];
  end

  // a replaced window holds no SYM_ZERO run, so patterns never overlap
  assign run_hit = (&is_zero) && (fill_q >= FILL_HIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) sym_q[i] <= SYM_ZERO;
      fill_q <= '0;
    end else if (shift_i) begin
      for (int i = 0; i < DEPTH; i++) sym_q[i] <= sym_d[i];
      if (fill_q != FILL_MAX) fill_q <= fill_q + 1'b1;
    end
  end

  assign head_o = sym_q[DEPTH-1];
  assign full_o = (fill_q == FILL_MAX);

endmodule

// File: rtl/b8zs_polarity.sv
module b8zs_polarity
  import b8zs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic emit_i,
  input  sym_e sym_i,
  output logic pos_o,
  output logic neg_o,
  output logic valid_o
);

  logic last_pos_q;
  logic pulse;
  logic pol_pos;

  assign pulse   = (sym_i != SYM_ZERO);
  assign pol_pos = (sym_i == SYM_VIOL) ? last_pos_q : ~last_pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_pos_q <= 1'b0;
      pos_o      <= 1'b0;
      neg_o      <= 1'b0;
      valid_o    <= 1'b0;
    end else begin
      valid_o <= emit_i;
      pos_o   <= emit_i && pulse && pol_pos;
      neg_o   <= emit_i && pulse && !pol_pos;
      if (emit_i && pulse) last_pos_q <= pol_pos;
    end
  end

endmodule

// File: rtl/b8zs_encoder.sv
module b8zs_encoder
  import b8zs_pkg::*;
#(
  parameter int unsigned DEPTH = RUN_LEN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_valid_i,
  input  logic bit_i,
  output logic pos_o,
  output logic neg_o,
  output logic valid_o
);

  sym_e head;
  logic full;

  b8zs_window #(.DEPTH(DEPTH)) u_window (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (bit_valid_i),
    .bit_i   (bit_i),
    .head_o  (head),
    .full_o  (full)
  );

  b8zs_polarity u_polarity (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .emit_i  (bit_valid_i && full),
    .sym_i   (head),
    .pos_o   (pos_o),
    .neg_o   (neg_o),
    .valid_o (valid_o)
  );

endmodule

// File: rtl/b8zs_encoder_chk.sv
module b8zs_encoder_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_valid_i,
  input logic bit_i,
  input logic pos_o,
  input logic neg_o,
  input logic valid_o
);

  logic [3:0] strobe_cnt_q;
  logic [3:0] zero_run_q;
  logic       unused_bit;

  assign unused_bit = bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_cnt_q <= '0;
      zero_run_q   <= '0;
    end else begin
      if (bit_valid_i && strobe_cnt_q != 4'd15) strobe_cnt_q <= strobe_cnt_q + 1'b1;
      if (valid_o) begin
        if (pos_o || neg_o) zero_run_q <= '0;
        else if (zero_run_q != 4'd15) zero_run_q <= zero_run_q + 1'b1;
      end
    end
  end

  AST_RAILS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pos_o && neg_o)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!pos_o && !neg_o)); // R6

  AST_VALID_AFTER_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (strobe_cnt_q >= 4'd9)); // R5

  AST_NO_LONG_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !pos_o && !neg_o) |-> (zero_run_q < 4'd7)); // R7

  AST_VALID_FOLLOWS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_valid_i |=> !valid_o); // R8

endmodule

bind b8zs_encoder b8zs_encoder_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bit_valid_i (bit_valid_i),
  .bit_i       (bit_i),
  .pos_o       (pos_o),
  .neg_o       (neg_o),
  .valid_o     (valid_o)
);

// File: tb/b8zs_encoder_bench.sv
module b8zs_encoder_bench;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_valid_i = 1'b0;
  logic bit_i = 1'b0;
  logic pos_o, neg_o, valid_o;

  int total = 0;
  int bad = 0;
  int ncap = 0;
  int idle_noise = 0;
  logic [1:0] cap [64];

  always #2ns clk_i = ~clk_i;

  b8zs_encoder u_b8zs_encoder (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_valid_i (bit_valid_i),
    .bit_i       (bit_i),
    .pos_o       (pos_o),
    .neg_o       (neg_o),
    .valid_o     (valid_o)
  );

  // codes: 10 positive, 01 negative, 00 no pulse; inputs MSB first
  localparam int NVEC = 7;
  localparam logic [47:0] VEC [NVEC] = '{
    {16'hF0AC, 32'h9900_8490},  // R1 R2 alternation
    {16'h8060, 32'h8091_9800},  // R3 R4 after a positive mark
    {16'h00AA, 32'h0189_8484},  // R3 R4 straight after reset
    {16'h0000, 32'h0189_0189},  // R10 two patterns
    {16'h8080, 32'h8000_4000},  // R10 seven zeros pass
    {16'hC020, 32'h9018_9800},  // R3 after a negative mark
    {16'h0060, 32'h0189_2400}   // R10 nine zeros
  };

  function automatic string vec_tag(input int i);
    case (i)
      0: vec_tag = "R1 R2";
      1: vec_tag = "R3 R4";
      2: vec_tag = "R3 R4 R9";
      3: vec_tag = "R10";
      4: vec_tag = "R10 R1";
      5: vec_tag = "R3";
      default: vec_tag = "R10 R3";
    endcase
  endfunction

  always @(negedge clk_i) begin
    if (valid_o) begin
      if (ncap < 64) cap[ncap] = {pos_o, neg_o};
      ncap = ncap + 1;
    end else if (pos_o || neg_o) begin
      idle_noise = idle_noise + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    bit_valid_i = 1'b0;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    ncap = 0;
    rst_ni = 1'b1;
  endtask

  task automatic send_bit(input logic b, input int gap);
    @(negedge clk_i);
    bit_valid_i = 1'b1;
    bit_i = b;
    if (gap > 0) begin
      @(negedge clk_i);
      bit_valid_i = 1'b0;
      repeat (gap - 1) @(negedge clk_i);
    end
  endtask

  task automatic end_stream();
    @(negedge clk_i);
    bit_valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic run_vec(input logic [15:0] bits, input logic [31:0] exp, input int gap, input string tag);
    logic [31:0] got;
    int run;
    int maxrun;
    do_reset();
    for (int i = 15; i >= 0; i--) send_bit(bits[i], gap);
    for (int i = 0; i < 8; i++) send_bit(1'b1, gap);
    end_stream();
    check(ncap == 16, "R5 output count", 64'(ncap), 64'd16);
    got = '0;
    run = 0;
    maxrun = 0;
    for (int i = 0; i < 16; i++) begin
      got = {got[29:0], cap[i]};
      check(cap[i] != 2'b11, "R6 both rails", 64'(cap[i]), 64'd0);
      if (cap[i] == 2'b00) run++; else run = 0;
      if (run > maxrun) maxrun = run;
    end
    check(got == exp, tag, 64'(got), 64'(exp));
    check(maxrun < 8, "R7 quiet run", 64'(maxrun), 64'd7);
  endtask

  initial begin
    #(4ns * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R9 reset state
    repeat (2) @(negedge clk_i);
    check({pos_o, neg_o, valid_o} == 3'b000, "R9 reset outputs", 64'({pos_o, neg_o, valid_o}), 64'd0);
    rst_ni = 1'b1;

    for (int v = 0; v < NVEC; v++)
      run_vec(VEC[v][47:32], VEC[v][31:0], 0, vec_tag(v));

    // R8 idle gaps must not alter the coded stream
    run_vec(VEC[1][47:32], VEC[1][31:0], 3, "R8 gapped");
    check(idle_noise == 0, "R6 idle rails", 64'(idle_noise), 64'd0);

    // R5 fill latency and R2 first mark positive
    do_reset();
    for (int i = 0; i < 8; i++) send_bit(1'b1, 0);
    end_stream();
    check(ncap == 0, "R5 no output while filling", 64'(ncap), 64'd0);
    send_bit(1'b1, 0);
    end_stream();
    check(ncap == 1, "R5 first output", 64'(ncap), 64'd1);
    check(cap[0] == 2'b10, "R2 first mark positive", 64'(cap[0]), 64'h2);

    // R9 reset in mid stream
    do_reset();
    for (int i = 0; i < 10; i++) send_bit(1'b1, 0);
    @(negedge clk_i);
    bit_valid_i = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk_i);
    check(!valid_o && !pos_o && !neg_o, "R9 mid reset outputs", 64'({pos_o, neg_o, valid_o}), 64'd0);
    ncap = 0;
    rst_ni = 1'b1;
    for (int i = 0; i < 8; i++) send_bit(1'b1, 0);
    end_stream();
    check(ncap == 0, "R9 window emptied", 64'(ncap), 64'd0);
    send_bit(1'b0, 0);
    end_stream();
    check(ncap == 1 && cap[0] == 2'b10, "R9 polarity restored", 64'({ncap[7:0], 6'd0, cap[0]}), 64'h0102);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule